// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the already filtered levels of a bank of GPIO pins into interrupt requests, one per pin. Each pin carries its own enable bit, mask bit, trigger-type bit and a 2-bit polarity code. In edge mode a qualifying transition sets a sticky status bit. Software clears that bit by writing a one to it through a simple write strobe. In level mode the status bit tracks the qualified level. The per-pin request goes to an interrupt aggregator. No acknowledge step is needed before servicing: the request simply stays up until its cause goes away.

Each pin samples its input once per clock. Edges are found by comparing the incoming level with that sample. The sample is also output as the readable pin state, whether or not the pin is driven.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every status bit and every request output is 0.
- R2: In edge mode (trigger bit 0), polarity code 01 sets the pin's status on a rising edge and code 00 sets it on a falling edge. The status is visible one clock after the edge is presented. An edge of the opposite direction does not set the status.
- R3: In edge mode, polarity code 10 sets the status on both rising and falling edges.
- R4: Polarity code 11 never sets the status, in either mode.
- R5: In edge mode the status stays set until a write with the strobe high and that pin's data bit at 1 clears it on the next clock. Data bits at 0 leave their pins untouched.
- R6: If a qualifying edge and a clearing write for the same pin fall in the same cycle, the status ends up set.
- R7: In level mode (trigger bit 1), the status one clock later equals the qualified level. Code 01 qualifies a high level and code 00 a low level. Clearing writes have no effect in this mode.
- R8: A request is high exactly when the status, the enable bit and the mask bit (1 = unmasked) are all 1. A masked pin still records edges in its status.
- R9: With the enable bit at 0, no edge or level sets the status.
- R10: The pin-state output shows the input level sampled at the last clock, independent of any configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | PINS | Filtered pin levels |
| irq_en | input | PINS | Per-pin interrupt enable |
| irq_unmask | input | PINS | Per-pin mask bit, 1 = unmasked |
| lvl_trig | input | PINS | 1 = level trigger, 0 = edge trigger |
| act_sel | input | 2*PINS | Per-pin polarity code, pin g in bits 2g+1:2g |
| clr_wr | input | 1 | Status write strobe |
| clr_data | input | PINS | Write-one-to-clear data |
| pin_state | output | PINS | Sampled pin level |
| int_sts | output | PINS | Per-pin interrupt status |
| irq_req | output | PINS | Per-pin interrupt request |

## Verification
Two things can hit the same status bit in one clock: a qualifying edge that sets it and a clearing write that resets it. The bench provokes this by raising the pin and pulsing the strobe with that pin's data bit in the same cycle. It then requires the status to read 1, so the set must win. It also checks the opposite cases: a write to a different pin's bit leaves the status alone, and a write in level mode is ignored.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_lvl,
  input  logic [PINS-1:0]   irq_en,
  input  logic [PINS-1:0]   irq_unmask,
  input  logic [PINS-1:0]   lvl_trig,
  input  logic [2*PINS-1:0] act_sel,
  input  logic              clr_wr,
  input  logic [PINS-1:0]   clr_data,
  output logic [PINS-1:0]   pin_state,
  output logic [PINS-1:0]   int_sts,
  output logic [PINS-1:0]   irq_req
);
  logic [PINS-1:0] lvl_q;
  logic [PINS-1:0] sts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= pin_lvl;
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic [1:0] sel;
    logic rise, fall, edge_hit, lvl_hit;
    assign sel  = act_sel[2*g +: 2];
    assign rise = pin_lvl[g] & ~lvl_q[g];
    assign fall = ~pin_lvl[g] & lvl_q[g];
    assign edge_hit = irq_en[g] & ((sel == 2'b01 & rise) |
                                   (sel == 2'b00 & fall) |
                                   (sel == 2'b10 & (rise | fall)));
    assign lvl_hit  = irq_en[g] & ((sel == 2'b01 &  pin_lvl[g]) |
                                   (sel == 2'b00 & ~pin_lvl[g]));

    always_ff @(posedge clk) begin
      if (!rst_n)                    sts_q[g] <= 1'b0;
      else if (lvl_trig[g])          sts_q[g] <= lvl_hit;
      else if (edge_hit)             sts_q[g] <= 1'b1;
      else if (clr_wr & clr_data[g]) sts_q[g] <= 1'b0;
    end
  end

  assign pin_state = lvl_q;
  assign int_sts   = sts_q;
  assign irq_req   = sts_q & irq_en & irq_unmask;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int PINS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PINS-1:0]   pin_lvl,
  input logic [PINS-1:0]   irq_en,
  input logic [PINS-1:0]   irq_unmask,
  input logic [PINS-1:0]   lvl_trig,
  input logic [2*PINS-1:0] act_sel,
  input logic              clr_wr,
  input logic [PINS-1:0]   clr_data,
  input logic [PINS-1:0]   pin_state,
  input logic [PINS-1:0]   int_sts,
  input logic [PINS-1:0]   irq_req
);
  for (genvar g = 0; g < PINS; g++) begin : g_chk
    p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_trig[g] && irq_en[g] && act_sel[2*g +: 2] == 2'b01 && pin_lvl[g] && !pin_state[g])
      |=> int_sts[g]);
    p_code11_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_sel[2*g +: 2] == 2'b11 && !int_sts[g]) |=> !int_sts[g]);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_trig[g] && int_sts[g] && !(clr_wr && clr_data[g])) |=> int_sts[g]);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_trig[g] && clr_wr && clr_data[g] && pin_lvl[g] == pin_state[g]) |=> !int_sts[g]);
    p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_trig[g] && irq_en[g] && act_sel[2*g +: 2] == 2'b01) |=> (int_sts[g] == $past(pin_lvl[g])));
    p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_unmask[g] || !irq_en[g]) |-> !irq_req[g]);
    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en[g] && !int_sts[g]) |=> !int_sts[g]);
    p_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pin_state[g] == $past(pin_lvl[g])));
  end
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.PINS(PINS)) u_chk (.*);

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  localparam int PINS = 4;
  localparam time PERIOD = 10;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [PINS-1:0]   pin_lvl = '0;
  logic [PINS-1:0]   irq_en = '0;
  logic [PINS-1:0]   irq_unmask = '0;
  logic [PINS-1:0]   lvl_trig = '0;
  logic [2*PINS-1:0] act_sel = '0;
  logic              clr_wr = 0;
  logic [PINS-1:0]   clr_data = '0;
  logic [PINS-1:0]   pin_state, int_sts, irq_req;

  int n_run = 0;
  int n_fail = 0;

  gpio_irq_detect #(.PINS(PINS)) u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg0(logic en, logic unm, logic lvl, logic [1:0] sel);
    irq_en = {3'b000, en};
    irq_unmask = {3'b000, unm};
    lvl_trig = {3'b000, lvl};
    act_sel = {6'b0, sel};
  endtask

  task automatic clear_all();
    cfg0(0, 0, 0, 2'b11);
    clr_wr = 1; clr_data = '1;
    step();
    clr_wr = 0; clr_data = '0;
    pin_lvl = '0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 status", int_sts, 0);
    chk("R1 request", irq_req, 0);
  endtask

  task automatic t_rise();
    clear_all();
    cfg0(1, 1, 0, 2'b01);
    step();
    pin_lvl[0] = 1; step();
    chk("R2 rise sets", int_sts[0], 1);
    chk("R8 request", irq_req[0], 1);
    pin_lvl[0] = 0; step();
    chk("R5 sticky", int_sts[0], 1);
    clr_wr = 1; clr_data = 4'b0010; step();
    chk("R5 other bit", int_sts[0], 1);
    clr_data = 4'b0001; step();
    clr_wr = 0; clr_data = 0;
    chk("R5 cleared", int_sts[0], 0);
    chk("R5 req low", irq_req[0], 0);
  endtask

  task automatic t_fall();
    clear_all();
    cfg0(1, 1, 0, 2'b00);
    pin_lvl[0] = 1; step();
    chk("R2 rise ignored", int_sts[0], 0);
    pin_lvl[0] = 0; step();
    chk("R2 fall sets", int_sts[0], 1);
  endtask

  task automatic t_both();
    clear_all();
    cfg0(1, 1, 0, 2'b10);
    pin_lvl[0] = 1; step();
    chk("R3 rise", int_sts[0], 1);
    clr_wr = 1; clr_data = 1; step();
    clr_wr = 0; clr_data = 0;
    chk("R3 cleared", int_sts[0], 0);
    pin_lvl[0] = 0; step();
    chk("R3 fall", int_sts[0], 1);
  endtask

  task automatic t_code11();
    clear_all();
    cfg0(1, 1, 0, 2'b11);
    pin_lvl[0] = 1; step();
    chk("R4 edge rise", int_sts[0], 0);
    pin_lvl[0] = 0; step();
    chk("R4 edge fall", int_sts[0], 0);
    cfg0(1, 1, 1, 2'b11);
    pin_lvl[0] = 1; step(); step();
    chk("R4 level", int_sts[0], 0);
  endtask

  task automatic t_collide();
    clear_all();
    cfg0(1, 1, 0, 2'b01);
    step();
    pin_lvl[0] = 1; clr_wr = 1; clr_data = 1; step();
    clr_wr = 0; clr_data = 0;
    chk("R6 edge wins", int_sts[0], 1);
  endtask

  task automatic t_mask();
    clear_all();
    cfg0(1, 0, 0, 2'b01);
    pin_lvl[0] = 1; step();
    chk("R8 masked status", int_sts[0], 1);
    chk("R8 masked req", irq_req[0], 0);
    irq_unmask[0] = 1; #1;
    chk("R8 unmasked req", irq_req[0], 1);
    irq_en[0] = 0; #1;
    chk("R8 disabled req", irq_req[0], 0);
  endtask

  task automatic t_disable();
    clear_all();
    cfg0(0, 1, 0, 2'b10);
    pin_lvl[0] = 1; step();
    chk("R9 edge", int_sts[0], 0);
    lvl_trig[0] = 1; act_sel[1:0] = 2'b01; step();
    chk("R9 level", int_sts[0], 0);
  endtask

  task automatic t_level();
    clear_all();
    cfg0(1, 1, 1, 2'b01);
    pin_lvl[0] = 1; step();
    chk("R7 high", int_sts[0], 1);
    chk("R7 req", irq_req[0], 1);
    clr_wr = 1; clr_data = 1; step();
    clr_wr = 0; clr_data = 0;
    chk("R7 clear ignored", int_sts[0], 1);
    pin_lvl[0] = 0; step();
    chk("R7 drops", int_sts[0], 0);
    act_sel[1:0] = 2'b00; step();
    chk("R7 active low", int_sts[0], 1);
  endtask

  task automatic t_state();
    clear_all();
    pin_lvl = 4'b1010; step();
    chk("R10 state", pin_state, 4'b1010);
    chk("R10 no status", int_sts, 0);
    pin_lvl = 4'b0101; step();
    chk("R10 state2", pin_state, 4'b0101);
  endtask

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_rise();
    t_fall();
    t_both();
    t_code11();
    t_collide();
    t_mask();
    t_disable();
    t_level();
    t_state();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule